// File: doc/BRIEF.md
# Glitch-free two-source CPU clock selector

This block chooses which of two free-running clocks drives the CPU clock pin: the base system clock, or a programmable control clock generated elsewhere. Software selects a source by writing to one of two I/O ports. The port decoder turns each write into a one-cycle strobe, synchronous to the base clock. One strobe asks for the control clock. The other asks for a return to the base clock. A status bit, meant for a read-back port, reports whether the control clock is the one currently gated through.

The request is kept in a set/reset register. If both strobes arrive together, the base-clock request wins. A second register, the committed selection, follows the request only once the previous changeover has fully finished. Each clock has its own enable flip-flop, updated on that clock's falling edge, so an enable only changes while its clock is low. An enable may turn on only after the other domain's enable has been seen off through a synchroniser. The output is therefore never driven by both clocks at once and never carries a shortened pulse. Between the two sources the output rests low.

Top module: `clksel_top`

## Requirements
- R1: While reset is held and after it is released, the base clock is selected: `ctl_active` reads 0 and `cpu_clk` follows `clk_base`. Reset asserted at any time returns the block to this state.
- R2: A one-cycle pulse on `sel_ctl_stb` (sampled on a rising edge of `clk_base`) moves the output to the control clock. Within 25 base-clock cycles `ctl_active` reads 1 and `cpu_clk` follows `clk_ctl`.
- R3: A one-cycle pulse on `sel_base_stb` returns the output to the base clock. Within 25 base-clock cycles `ctl_active` reads 0 and `cpu_clk` follows `clk_base`.
- R4: When both strobes are high in the same sampled cycle, the request is for the base clock.
- R5: The two clock enables are never both active.
- R6: Each enable changes only while its own clock is low. `cpu_clk` therefore never shows a high or low pulse shorter than the shorter half-period of the two clocks.
- R7: An enable rises only after the other clock's enable, seen through a synchroniser in its own domain, is clear.
- R8: A strobe asking for the clock already in use has no effect: `ctl_active` and `cpu_clk` do not change.
- R9: The requested selection is held after its strobe ends. A strobe that arrives during a changeover is kept and applied once that changeover has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Base system clock; also the domain of the strobes |
| clk_ctl | input | 1 | Programmable control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_ctl_stb | input | 1 | One-cycle request for the control clock |
| sel_base_stb | input | 1 | One-cycle request for the base clock |
| cpu_clk | output | 1 | Selected CPU clock |
| ctl_active | output | 1 | 1 when the control clock is gated through (base-clock domain) |

## Verification
The assertions take both strobes to be synchronous to the rising edge of `clk_base`. They also take both clocks to keep running during a changeover, since a stopped clock leaves its enable frozen and the handover stalls. The bench drives each strobe for exactly one base-clock period, changing it at falling edges. It keeps both clocks free-running for the whole run, with unrelated periods. It silences its pulse-width monitor only across the asynchronous reset pulses, because a reset is allowed to cut a pulse.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  typedef enum logic {
    SRC_BASE = 1'b0,
    SRC_CTL  = 1'b1
  } clk_src_e;

  localparam int unsigned SYNC_MIN_STAGES = 2;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage synchroniser into the domain of clk.
module clksel_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clksel_gate.sv
`timescale 1ns/1ps
// Enable flop updated on the falling edge, while its own clock is low.
module clksel_gate #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  output logic en
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= RST_VAL;
    else        en <= allow;
  end
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
// Request latch and committed selection, base-clock domain.
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stb_ctl,
  input  logic     stb_base,
  input  logic     base_en,
  input  logic     ctl_en_seen,
  output clk_src_e want_o,
  output clk_src_e commit_o
);
  clk_src_e want_q, want_d, commit_q;
  logic     settled;

  // Base request has priority over control request.
  always_comb begin
    want_d = want_q;
    if (stb_base)     want_d = SRC_BASE;
    else if (stb_ctl) want_d = SRC_CTL;
  end

  // The last commit is complete once both enables agree with it.
  always_comb begin
    if (commit_q == SRC_CTL) settled = ctl_en_seen && !base_en;
    else                     settled = !ctl_en_seen && base_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q   <= SRC_BASE;
      commit_q <= SRC_BASE;
    end else begin
      want_q <= want_d;
      if (settled) commit_q <= want_q;
    end
  end

  assign want_o   = want_q;
  assign commit_o = commit_q;
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top
  import clksel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_base,
  input  logic clk_ctl,
  input  logic rst_n,
  input  logic sel_ctl_stb,
  input  logic sel_base_stb,
  output logic cpu_clk,
  output logic ctl_active
);
  localparam int unsigned STAGES =
    (SYNC_STAGES < SYNC_MIN_STAGES) ? SYNC_MIN_STAGES : SYNC_STAGES;

  clk_src_e   want, commit;
  logic       base_en, ctl_en;
  logic       ctl_en_b;
  logic       commit_c, base_en_c;
  logic [1:0] to_ctl_d, to_ctl_q;
  logic       base_allow, ctl_allow;

  clksel_ctrl u_ctrl (
    .clk         (clk_base),
    .rst_n       (rst_n),
    .stb_ctl     (sel_ctl_stb),
    .stb_base    (sel_base_stb),
    .base_en     (base_en),
    .ctl_en_seen (ctl_en_b),
    .want_o      (want),
    .commit_o    (commit)
  );

  assign base_allow = (commit == SRC_BASE) && !ctl_en_b;

  clksel_gate #(.RST_VAL(1'b1)) u_base_gate (
    .clk   (clk_base),
    .rst_n (rst_n),
    .allow (base_allow),
    .en    (base_en)
  );

  assign to_ctl_d = {commit == SRC_CTL, base_en};

  clksel_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b01)) u_to_ctl (
    .clk   (clk_ctl),
    .rst_n (rst_n),
    .d     (to_ctl_d),
    .q     (to_ctl_q)
  );

  assign commit_c  = to_ctl_q[1];
  assign base_en_c = to_ctl_q[0];
  assign ctl_allow = commit_c && !base_en_c;

  clksel_gate #(.RST_VAL(1'b0)) u_ctl_gate (
    .clk   (clk_ctl),
    .rst_n (rst_n),
    .allow (ctl_allow),
    .en    (ctl_en)
  );

  clksel_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_to_base (
    .clk   (clk_base),
    .rst_n (rst_n),
    .d     (ctl_en),
    .q     (ctl_en_b)
  );

  assign cpu_clk    = (clk_base & base_en) | (clk_ctl & ctl_en);
  assign ctl_active = ctl_en_b;
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk (
  input logic clk_base,
  input logic clk_ctl,
  input logic rst_n,
  input logic sel_ctl_stb,
  input logic sel_base_stb,
  input logic want,
  input logic base_en,
  input logic ctl_en,
  input logic commit_c,
  input logic base_en_c,
  input logic ctl_en_b
);
  // R4
  both_stb_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    (sel_ctl_stb && sel_base_stb) |=> !want);

  // R2
  ctl_req_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    (sel_ctl_stb && !sel_base_stb) |=> want);

  // R9
  req_hold_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    (!sel_ctl_stb && !sel_base_stb) |=> $stable(want));

  // R5
  excl_base_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    !(base_en && ctl_en));

  // R5
  excl_ctl_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    !(base_en && ctl_en));

  // R7
  ctl_rise_chk: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $rose(ctl_en) |-> (commit_c && !base_en_c));

  // R7
  base_rise_chk: assert property (@(posedge clk_base) disable iff (!rst_n)
    $rose(base_en) |-> !ctl_en_b);

  // R6
  always @(base_en) begin
    if (rst_n === 1'b1) base_low_chk: assert (clk_base === 1'b0);
  end

  // R6
  always @(ctl_en) begin
    if (rst_n === 1'b1) ctl_low_chk: assert (clk_ctl === 1'b0);
  end
endmodule

bind clksel_top clksel_chk chk (
  .clk_base     (clk_base),
  .clk_ctl      (clk_ctl),
  .rst_n        (rst_n),
  .sel_ctl_stb  (sel_ctl_stb),
  .sel_base_stb (sel_base_stb),
  .want         (want),
  .base_en      (base_en),
  .ctl_en       (ctl_en),
  .commit_c     (commit_c),
  .base_en_c    (base_en_c),
  .ctl_en_b     (ctl_en_b)
);

// File: tb/tb_clksel_top.sv
`timescale 1ns/1ps
module tb_clksel_top;
  logic clk_base = 1'b0;
  logic clk_ctl  = 1'b0;
  logic rst_n    = 1'b0;
  logic sel_ctl_stb  = 1'b0;
  logic sel_base_stb = 1'b0;
  logic cpu_clk, ctl_active;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk_base = ~clk_base;  // 50 MHz
  always #15 clk_ctl  = ~clk_ctl;   // unrelated control clock

  clksel_top dut (
    .clk_base     (clk_base),
    .clk_ctl      (clk_ctl),
    .rst_n        (rst_n),
    .sel_ctl_stb  (sel_ctl_stb),
    .sel_base_stb (sel_base_stb),
    .cpu_clk      (cpu_clk),
    .ctl_active   (ctl_active)
  );

  // Pulse-width monitor on the output (R6)
  bit  mon_en = 1'b0;
  real last_t = -1.0;
  real min_w  = 1.0e9;
  always @(cpu_clk) begin
    if (mon_en) begin
      if (last_t >= 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      last_t = $realtime;
    end
  end

  // {ctl strobe, base strobe, expected ctl_active, kind}
  // kind: 0 -> R2, 1 -> R3, 2 -> R8, 3 -> R4
  localparam int NV = 8;
  localparam logic [4:0] VEC [NV] = '{
    5'b1_0_1_00, 5'b1_0_1_10, 5'b0_1_0_01, 5'b0_1_0_10,
    5'b1_0_1_00, 5'b1_1_0_11, 5'b1_1_0_11, 5'b1_0_1_00
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic b);
    @(negedge clk_base);
    sel_ctl_stb  = c;
    sel_base_stb = b;
    @(negedge clk_base);
    sel_ctl_stb  = 1'b0;
    sel_base_stb = 1'b0;
  endtask

  task automatic follow(input bit want_ctl, input string req);
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_base); #3;
      if (cpu_clk !== (want_ctl ? clk_ctl : clk_base)) bad++;
      @(negedge clk_base); #3;
      if (cpu_clk !== (want_ctl ? clk_ctl : clk_base)) bad++;
    end
    chk(bad == 0, req, "cpu_clk source mismatches", bad, 0);
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    @(negedge clk_base);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_base);
    rst_n = 1'b1;
    last_t = -1.0;
    mon_en = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_base);
    #3;
    chk(ctl_active === 1'b0, "R1", "ctl_active during reset", int'(ctl_active), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (4) @(posedge clk_base);
    #3;
    chk(ctl_active === 1'b0, "R1", "ctl_active after reset", int'(ctl_active), 0);
    follow(1'b0, "R1");

    // Vector table
    for (int v = 0; v < NV; v++) begin
      string tag;
      int dev = 0;
      case (VEC[v][1:0])
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R8";
        default: tag = "R4";
      endcase
      pulse(VEC[v][4], VEC[v][3]);
      for (int c = 0; c < 25; c++) begin
        @(posedge clk_base); #3;
        if (VEC[v][1:0] == 2'd2 && ctl_active !== VEC[v][2]) dev++;
      end
      if (VEC[v][1:0] == 2'd2)
        chk(dev == 0, tag, "status moved on repeated strobe", dev, 0);
      chk(ctl_active === VEC[v][2], tag, "ctl_active after strobe",
          int'(ctl_active), int'(VEC[v][2]));
      follow(VEC[v][2], (VEC[v][2] ? "R2,R5,R7 " : "R3,R5,R7 "));
    end

    // R9: base request, then control request during the changeover
    begin
      bit seen_base = 1'b0;
      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b0);
      for (int c = 0; c < 40; c++) begin
        @(posedge clk_base); #3;
        if (ctl_active === 1'b0) seen_base = 1'b1;
      end
      chk(seen_base, "R9", "first handover completed before pending request",
          int'(seen_base), 1);
      chk(ctl_active === 1'b1, "R9", "pending control request applied",
          int'(ctl_active), 1);
      follow(1'b1, "R9");
    end

    // R1: reset while the control clock is selected
    do_reset();
    @(posedge clk_base); #3;
    chk(ctl_active === 1'b0, "R1", "ctl_active after mid-run reset", int'(ctl_active), 0);
    follow(1'b0, "R1");

    // R2 once more after reset, then R6 pulse-width summary
    pulse(1'b1, 1'b0);
    repeat (25) @(posedge clk_base);
    #3;
    chk(ctl_active === 1'b1, "R2", "ctl_active after reset and strobe", int'(ctl_active), 1);
    pulse(1'b0, 1'b1);
    repeat (25) @(posedge clk_base);
    #3;
    chk(ctl_active === 1'b0, "R3", "ctl_active after final return", int'(ctl_active), 0);
    chk(min_w > 9.5, "R6", "shortest cpu_clk pulse (ns)", int'(min_w), 10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule